// File: doc/BRIEF.md
# Loss-of-Signal Qualifier

This block turns a raw, possibly noisy, loss-of-signal comparator indication into a clean loss-of-signal decision. The decision is timed against a free-running bit clock that comes from the local reference. The block has two raw inputs. The first is an active-high indication for electrical line mode. The second is an active-low indication from an optical receiver module. A static mode select chooses which of the two counts. Both raw inputs pass through a two-flop synchronizer. A persistence counter then requires the selected indication to hold for a parameterized number of bit intervals before loss is declared.

While loss is declared, the block holds the serial data output at zero. It also sets the reference select output so that clock recovery tracks the local reference clock instead of the incoming stream, and it drives the active-low lock status low. A loss is cleared only after a run of consecutive clear samples, which keeps the outputs from chattering near the threshold. With no loss declared, incoming data passes straight through to the output.

Top module: `los_qualifier`

## Requirements
- R1: After reset, and until a loss is declared, ref_sel_o is 0, lock_no is 1 and data_o equals data_i.
- R2: A loss is declared when the selected indication has been active on LOS_WINDOW consecutive synchronized samples. With the raw input changed just after a clock edge, ref_sel_o rises on the LOS_WINDOW+2-th following edge and not before. LOS_WINDOW must lie in 96..224 and defaults to 160.
- R3: A single clear sample of the selected indication before the window completes restarts the count from zero. A full window is then needed again.
- R4: While loss is declared, data_o is 0 whatever data_i is.
- R5: ref_sel_o is 1 (follow the local reference clock) exactly while loss is declared, and 0 (follow incoming data) otherwise.
- R6: lock_no is the inverse of ref_sel_o: high while clock recovery follows the data, low on loss.
- R7: With mode_optical_i = 1, loss is indicated by los_opt_ni = 0, and los_elec_i has no effect.
- R8: With mode_optical_i = 0, loss is indicated by los_elec_i = 1, and los_opt_ni has no effect.
- R9: A declared loss clears when the selected indication is inactive on RECOVER_LEN (default 16) consecutive synchronized samples. ref_sel_o falls on the RECOVER_LEN+2-th edge after the raw input clears. An active sample during recovery restarts that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running bit clock derived from the local reference |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_optical_i | input | 1 | 1 selects the optical loss input, 0 selects the electrical input |
| los_elec_i | input | 1 | Raw electrical loss indication, active high |
| los_opt_ni | input | 1 | Raw optical loss indication, active low |
| data_i | input | 1 | Incoming serial NRZ data |
| data_o | output | 1 | Serial data out, forced to 0 during loss |
| ref_sel_o | output | 1 | Clock-recovery reference select, 1 = local reference clock |
| lock_no | output | 1 | Active-low loss status, high while locked to data |

## Verification
A persistence counter in the wrong state shows up as a loss edge that lands one or more cycles away from the LOS_WINDOW+2 edge. The bench observes that at the very edge where the decision should fall. A restart that fails to clear the count shows as a premature loss after a short interruption. A stuck loss flag shows at once, because data_o goes constant zero and ref_sel_o and lock_no disagree with the expected state on the next sample. A wrong mode path shows as a loss declared on the unselected input, or as a loss that never comes, within one window length.

// File: rtl/los_pkg.sv
package los_pkg;
  localparam int unsigned LOS_WINDOW_MIN = 96;
  localparam int unsigned LOS_WINDOW_MAX = 224;
  typedef enum logic {
    LINK_UP   = 1'b0,
    LINK_LOST = 1'b1
  } link_state_e;
endpackage

// File: rtl/los_sync.sv
module los_sync #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [STAGES-1:0][N-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/los_persist.sv
module los_persist
  import los_pkg::*;
#(
  parameter int unsigned LOS_WINDOW  = 160,
  parameter int unsigned RECOVER_LEN = 16,
  localparam int unsigned CNT_MAX    = (LOS_WINDOW > RECOVER_LEN) ? LOS_WINDOW : RECOVER_LEN,
  localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  output logic             lost_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(LOS_WINDOW - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(RECOVER_LEN - 1);

  link_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LINK_UP;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        LINK_UP: begin
          if (!raw_i)                cnt_q <= '0;
          else if (cnt_q == WIN_LAST) begin
            state_q <= LINK_LOST;
            cnt_q   <= '0;
          end else                   cnt_q <= cnt_q + 1'b1;
        end
        LINK_LOST: begin
          if (raw_i)                 cnt_q <= '0;
          else if (cnt_q == REC_LAST) begin
            state_q <= LINK_UP;
            cnt_q   <= '0;
          end else                   cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          state_q <= LINK_UP;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign lost_o = (state_q == LINK_LOST);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/los_out_stage.sv
module los_out_stage (
  input  logic lost_i,
  input  logic data_i,
  output logic data_o,
  output logic ref_sel_o,
  output logic lock_no
);
  assign data_o    = data_i & ~lost_i;
  assign ref_sel_o = lost_i;
  assign lock_no   = ~lost_i;
endmodule

// File: rtl/los_qualifier.sv
module los_qualifier
  import los_pkg::*;
#(
  parameter int unsigned LOS_WINDOW  = 160,
  parameter int unsigned RECOVER_LEN = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_MAX    = (LOS_WINDOW > RECOVER_LEN) ? LOS_WINDOW : RECOVER_LEN,
  localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_optical_i,
  input  logic los_elec_i,
  input  logic los_opt_ni,
  input  logic data_i,
  output logic data_o,
  output logic ref_sel_o,
  output logic lock_no
);
  if (LOS_WINDOW < LOS_WINDOW_MIN || LOS_WINDOW > LOS_WINDOW_MAX) begin : g_bad_window
    $error("LOS_WINDOW out of range");
  end

  logic [1:0]       raw_s;
  logic             sel_s;
  logic             lost;
  logic [CNT_W-1:0] cnt;

  // bit 1: optical (converted to active high), bit 0: electrical
  los_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({~los_opt_ni, los_elec_i}),
    .q_o   (raw_s)
  );

  assign sel_s = mode_optical_i ? raw_s[1] : raw_s[0];

  los_persist #(.LOS_WINDOW(LOS_WINDOW), .RECOVER_LEN(RECOVER_LEN)) u_persist (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (sel_s),
    .lost_o(lost),
    .cnt_o (cnt)
  );

  los_out_stage u_out (
    .lost_i   (lost),
    .data_i   (data_i),
    .data_o   (data_o),
    .ref_sel_o(ref_sel_o),
    .lock_no  (lock_no)
  );
endmodule

// File: rtl/los_qualifier_chk.sv
module los_qualifier_chk #(
  parameter int unsigned LOS_WINDOW  = 160,
  parameter int unsigned RECOVER_LEN = 16,
  parameter int unsigned CNT_W       = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             data_i,
  input logic             data_o,
  input logic             ref_sel_o,
  input logic             lock_no,
  input logic             sel_s,
  input logic [CNT_W-1:0] cnt
);
  // R2
  los_rise_after_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_sel_o) |-> ($past(sel_s) && $past(cnt) == CNT_W'(LOS_WINDOW - 1)));

  // R3
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_sel_o && !sel_s) |=> (cnt == '0));

  // R4
  data_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_sel_o |-> !data_o);

  // R6
  lock_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_no == !ref_sel_o);

  // R9
  los_fall_after_recover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ref_sel_o) |-> (!$past(sel_s) && $past(cnt) == CNT_W'(RECOVER_LEN - 1)));

  // R1
  data_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_sel_o |-> (data_o == data_i));
endmodule

bind los_qualifier los_qualifier_chk #(
  .LOS_WINDOW (LOS_WINDOW),
  .RECOVER_LEN(RECOVER_LEN),
  .CNT_W      (CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .data_i   (data_i),
  .data_o   (data_o),
  .ref_sel_o(ref_sel_o),
  .lock_no  (lock_no),
  .sel_s    (sel_s),
  .cnt      (cnt)
);

// File: tb/los_qualifier_test.sv
`timescale 1ns/1ps
module los_qualifier_test;
  localparam int W = 160;
  localparam int R = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_optical_i = 1'b0;
  logic los_elec_i = 1'b0;
  logic los_opt_ni = 1'b1;
  logic data_i = 1'b0;
  logic data_o, ref_sel_o, lock_no;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  los_qualifier #(.LOS_WINDOW(W), .RECOVER_LEN(R)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_optical_i(mode_optical_i),
    .los_elec_i(los_elec_i), .los_opt_ni(los_opt_ni), .data_i(data_i),
    .data_o(data_o), .ref_sel_o(ref_sel_o), .lock_no(lock_no)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // advance n edges, then sit mid-cycle
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk_state(input string req, input logic lost);
    chk(req, "ref_sel_o", ref_sel_o, lost);
    chk(req, "lock_no", lock_no, ~lost);
  endtask

  task automatic chk_data(input string req, input logic lost);
    data_i = 1'b1; #1;
    chk(req, "data_o hi", data_o, lost ? 1'b0 : 1'b1);
    data_i = 1'b0; #1;
    chk(req, "data_o lo", data_o, 1'b0);
  endtask

  task automatic do_reset;
    rst_ni = 1'b0;
    los_elec_i = 1'b0; los_opt_ni = 1'b1;
    edges(2);
    rst_ni = 1'b1;
    edges(1);
  endtask

  task automatic t_reset;
    do_reset();
    chk_state("R1", 1'b0);
    chk_data("R1", 1'b0);
  endtask

  // set the selected raw input active (1) or clear (0)
  task automatic drive_sel(input logic act);
    if (mode_optical_i) los_opt_ni = ~act;
    else                los_elec_i = act;
  endtask

  task automatic t_declare(input logic optical);
    mode_optical_i = optical;
    do_reset();
    drive_sel(1'b1);
    edges(W + 1);
    chk_state(optical ? "R7" : "R2", 1'b0);
    edges(1);
    chk_state(optical ? "R7" : "R2", 1'b1);
    chk_state("R5", 1'b1);
    chk_data("R4", 1'b1);
    chk_state("R6", 1'b1);
  endtask

  task automatic t_recover;
    // assumes loss currently declared
    drive_sel(1'b0);
    edges(R + 1);
    chk_state("R9", 1'b1);
    edges(1);
    chk_state("R9", 1'b0);
    chk_data("R1", 1'b0);
  endtask

  task automatic t_recover_restart;
    drive_sel(1'b0);
    edges(10);
    drive_sel(1'b1);
    edges(1);
    drive_sel(1'b0);
    edges(R + 1);
    chk_state("R9", 1'b1);
    edges(1);
    chk_state("R9", 1'b0);
  endtask

  task automatic t_glitch;
    mode_optical_i = 1'b0;
    do_reset();
    drive_sel(1'b1);
    edges(W - 1);
    drive_sel(1'b0);
    edges(1);
    drive_sel(1'b1);
    edges(W + 1);
    chk_state("R3", 1'b0);
    edges(1);
    chk_state("R3", 1'b1);
    drive_sel(1'b0);
    edges(R + 2);
    chk_state("R3", 1'b0);
  endtask

  task automatic t_ignore;
    // optical mode: electrical input has no effect
    mode_optical_i = 1'b1;
    do_reset();
    los_elec_i = 1'b1;
    edges(W + 20);
    chk_state("R7", 1'b0);
    chk_data("R7", 1'b0);
    los_elec_i = 1'b0;
    // electrical mode: optical input has no effect
    mode_optical_i = 1'b0;
    do_reset();
    los_opt_ni = 1'b0;
    edges(W + 20);
    chk_state("R8", 1'b0);
    chk_data("R8", 1'b0);
    los_opt_ni = 1'b1;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_declare(1'b0);
    t_recover();
    t_declare(1'b1);
    t_recover_restart();
    t_glitch();
    t_ignore();
    t_declare(1'b0);
    t_recover();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule